// File: doc/BRIEF.md
# Quadrature Position Counter with Timed Snapshot

This block turns the two phase signals of an incremental encoder into a position count for one servo axis. Both phases are first brought into the clock domain. A decoder then compares the current phase pair with the previous one. Every legal one-step move counts the position up or down by one, so each edge of either phase counts (four counts per encoder line). A move in which both phases change at once cannot be decoded. It leaves the count alone and sets a sticky fault flag.

The live count is never presented to the host directly. A built-in update timer, whose period the host programs, produces a single-cycle sample strobe. On that strobe the count is copied into a snapshot register, and an interrupt pulse tells the host that a fresh sample is ready. The strobe comes from hardware and not from software. When one timer feeds several such axes, all of them are sampled in the same clock cycle with no software jitter. The host reads the snapshot register and uses it for the servo loop.

Top module: `quad_capture_counter`

## Requirements
- R1: After reset the snapshot is 0, the interrupt is low, the fault flag is low, the position is 0 and the timer is disabled (period 0).
- R2: Each phase input passes through two flip-flops. With a period of 1, a phase change presented before clock edge E0 updates the position at edge E2, and the snapshot shows the new position after edge E3.
- R3: The phase pair (A,B) stepping 00→01→11→10→00, where B leads A, increments the position by one on each step.
- R4: The reverse order 00→10→11→01→00 decrements the position by one on each step.
- R5: The position wraps modulo 2^16: one step down from 0 gives 0xFFFF, and one step up from 0xFFFF gives 0.
- R6: A step in which A and B change together leaves the position unchanged and sets the fault flag. The flag stays set until a pulse on err_clr clears it. Decoding continues from the new phase pair.
- R7: The snapshot changes only on a timer strobe and holds its value between strobes.
- R8: When a count and a strobe fall in the same cycle, the snapshot takes the position from before that count.
- R9: Writing period P (P ≥ 1) restarts the timer. Strobes then occur every P cycles, and the first snapshot with its interrupt appears P cycles after the write edge. A period of 0 stops all strobes.
- R10: The interrupt is high for exactly the one cycle in which a new snapshot first becomes visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| per_wr | input | 1 | Write strobe for the timer period |
| per_data | input | 16 | New timer period in clock cycles, 0 disables the timer |
| err_clr | input | 1 | Clears the sticky fault flag |
| cap_value | output | 16 | Snapshot of the position, the host read data |
| irq | output | 1 | One-cycle pulse when a new snapshot is visible |
| quad_err | output | 1 | Sticky illegal-transition flag |

## Verification
The hardest case to reach from the ports is a count landing in the same cycle as a sample strobe. The count is hidden behind two synchronizer stages and the strobe comes from a free-running timer. The bench sets the period to 1, so every cycle is a strobe cycle. It then drives a phase change on a known falling edge and reads the snapshot on the third and fourth falling edges after that. At those points the snapshot must show the position before the count and then after it. Timer phase is handled the same way: every period change begins with a write, which restarts the timer on a known edge.

// File: rtl/quad_capture_counter.sv
module quad_capture_counter #(
  parameter int CNT_W = 16,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             per_wr,
  input  logic [PER_W-1:0] per_data,
  input  logic             err_clr,
  output logic [CNT_W-1:0] cap_value,
  output logic             irq,
  output logic             quad_err
);

  logic [1:0]       a_sync, b_sync, ab_q;
  logic [CNT_W-1:0] pos;
  logic [PER_W-1:0] per_q, tmr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sync <= '0;
      b_sync <= '0;
      ab_q   <= '0;
    end else begin
      a_sync <= {a_sync[0], enc_a};
      b_sync <= {b_sync[0], enc_b};
      ab_q   <= {a_sync[1], b_sync[1]};
    end
  end

  wire [1:0] ph_now = {a_sync[1], a_sync[1] ^ b_sync[1]};
  wire [1:0] ph_old = {ab_q[1], ab_q[1] ^ ab_q[0]};
  wire [1:0] delta  = ph_now - ph_old;
  wire       step_up = (delta == 2'd1);
  wire       step_dn = (delta == 2'd3);
  wire       bad     = (delta == 2'd2);

  wire strobe = (per_q != '0) && (tmr == per_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos       <= '0;
      cap_value <= '0;
      irq       <= 1'b0;
      quad_err  <= 1'b0;
    end else begin
      if (step_up)      pos <= pos + 1'b1;
      else if (step_dn) pos <= pos - 1'b1;
      if (strobe) cap_value <= pos;
      irq <= strobe;
      if (bad)          quad_err <= 1'b1;
      else if (err_clr) quad_err <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q <= '0;
      tmr   <= '0;
    end else if (per_wr) begin
      per_q <= per_data;
      tmr   <= '0;
    end else if (per_q != '0) begin
      tmr <= strobe ? '0 : tmr + 1'b1;
    end
  end

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pos == $past(pos)) || (pos == $past(pos) + 1'b1) || (pos == $past(pos) - 1'b1));

  assert_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> ($stable(pos) && quad_err));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(cap_value));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q == '0 && !per_wr) |=> ##1 !irq);

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && per_q > 1) |=> !irq);

endmodule

// File: tb/quad_capture_counter_tb.sv
module quad_capture_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0;
  logic        per_wr = 1'b0;
  logic [15:0] per_data = '0;
  logic        err_clr = 1'b0;
  logic [15:0] cap_value;
  logic        irq, quad_err;
  int total = 0, failed = 0;

  always #5 clk = ~clk;

  quad_capture_counter u_dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .per_wr(per_wr), .per_data(per_data), .err_clr(err_clr),
    .cap_value(cap_value), .irq(irq), .quad_err(quad_err)
  );

  // {A, B, expected snapshot, expected fault}
  localparam logic [18:0] VEC [11] = '{
    {2'b01, 16'h0001, 1'b0}, // R3
    {2'b11, 16'h0002, 1'b0}, // R3
    {2'b10, 16'h0003, 1'b0}, // R3
    {2'b00, 16'h0004, 1'b0}, // R3
    {2'b10, 16'h0003, 1'b0}, // R4
    {2'b11, 16'h0002, 1'b0}, // R4
    {2'b01, 16'h0001, 1'b0}, // R4
    {2'b00, 16'h0000, 1'b0}, // R4
    {2'b10, 16'hFFFF, 1'b0}, // R5 down wrap
    {2'b00, 16'h0000, 1'b0}, // R5 up wrap
    {2'b11, 16'h0000, 1'b1}  // R6 illegal
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_period(input logic [15:0] p);
    per_wr = 1'b1; per_data = p;
    nclk(1);
    per_wr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    failed++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    nclk(3);
    rst_n = 1'b1;
    nclk(1);
    chk("R1 snapshot", cap_value, 0);
    chk("R1 irq", irq, 0);
    chk("R1 fault", quad_err, 0);
    nclk(5);
    chk("R1 timer off", irq, 0);

    wr_period(16'd1);
    nclk(3);
    chk("R1 position zero", cap_value, 0);

    for (int i = 0; i < 11; i++) begin
      {enc_a, enc_b} = VEC[i][18:17];
      nclk(4);
      chk($sformatf("R3/R4/R5/R6 vec%0d snapshot", i), cap_value, VEC[i][16:1]);
      chk($sformatf("R6 vec%0d fault", i), quad_err, VEC[i][0]);
    end

    nclk(3);
    chk("R6 sticky", quad_err, 1);
    err_clr = 1'b1; nclk(1); err_clr = 1'b0;
    chk("R6 cleared", quad_err, 0);
    {enc_a, enc_b} = 2'b10;  // 11 -> 10 counts up from new state
    nclk(4);
    chk("R6 decode resumes", cap_value, 16'h0001);

    // R8: count and strobe in the same cycle, then R2 latency
    {enc_a, enc_b} = 2'b00;
    nclk(3);
    chk("R8 pre-count snapshot", cap_value, 16'h0001);
    nclk(1);
    chk("R2 new snapshot after third edge", cap_value, 16'h0002);

    // R9/R10: period 5
    wr_period(16'd5);
    for (int k = 2; k <= 16; k++) begin
      nclk(1);
      chk($sformatf("R9/R10 irq at cycle %0d", k), irq, (k == 6 || k == 11 || k == 16));
    end

    // R7/R9: period 0 stops strobes, snapshot holds
    wr_period(16'd0);
    {enc_a, enc_b} = 2'b10;
    for (int k = 0; k < 10; k++) begin
      nclk(1);
      if (irq) chk("R9 no irq when disabled", irq, 0);
    end
    chk("R7 snapshot held", cap_value, 16'h0002);
    wr_period(16'd1);
    nclk(2);
    chk("R7 snapshot after strobe", cap_value, 16'h0001);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule